// File: doc/BRIEF.md
# Packed BCD Multi-Byte Arithmetic Unit

This unit adds or subtracts decimal numbers that live in a small scratch RAM as packed BCD. Each byte carries two decimal digits, with the tens digit in the upper nibble. A number is addressed by the location of its least significant byte. Its more significant bytes sit at successively lower addresses, and the number is `span + 1` bytes long.

A command strobe starts an operation. The operation reads the first operand at pointer P. The second operand is either an 8-bit accumulator value or a second number at pointer Q that walks downward in step with P. The unit writes the decimal result back over the P operand, one byte position per clock. A carry or borrow passes from each byte position to the next more significant one. When the walk ends, the unit raises a one-cycle `done` and updates a carry flag and a zero flag, which hold until the next operation ends.

The RAM connection has two combinational read ports, one following P and one following Q, and one synchronous write port. These let a single cycle read both operand bytes and write the result byte.

Top module: `bcd_arith_unit`

## Requirements
- R1: While reset is low and after its release, `busy`, `done`, `carry`, `zero` and `wr_en` are 0.
- R2: Every byte is treated as two BCD digits, with the tens digit in bits 7:4 and the units digit in bits 3:0. Each result byte is the decimal sum or difference, reduced to 00..99.
- R3: An accepted command writes exactly `span + 1` bytes, one per clock, with `wr_en` high on each. The write addresses are P, P-1, P-2 and so on, and `wr_addr` always equals `rd_addr_a`.
- R4: With `op` = 00 (add accumulator), the BCD value of `acc` is added to the byte at P only. The more significant bytes receive only the carry that ripples up.
- R5: With `op` = 10 (add memory), the number whose least significant byte is at Q is added to the number at P. Byte j of the Q number is read from Q-j, and the carry chains between byte positions.
- R6: With `op` = 01 (subtract accumulator) or 11 (subtract memory), the second operand and the incoming borrow are subtracted. A byte position whose result would be negative adds 100 and passes a borrow of 1 to the next more significant position.
- R7: After an operation, `carry` equals the carry or borrow out of the most significant byte.
- R8: After an operation, `zero` is 1 exactly when every result byte written by that operation is 0x00.
- R9: `busy` is high during the write cycles only. `done` is high for exactly one cycle, the cycle after the last write.
- R10: A `start` that arrives while `busy` is high is ignored: no extra writes and no change to the running operation.
- R11: Pointers wrap modulo 2^AW, so a walk below address 0 continues at the top address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Command strobe, accepted when not busy |
| op | input | 2 | bit0: subtract; bit1: second operand from memory at Q |
| acc | input | 8 | Accumulator operand in packed BCD |
| p_ptr | input | AW | Address of the least significant byte of the P number |
| q_ptr | input | AW | Address of the least significant byte of the Q number |
| span | input | CW | Byte count minus one |
| rd_addr_a | output | AW | Read address for the P operand byte |
| rd_data_a | input | 8 | Combinational read data at `rd_addr_a` |
| rd_addr_b | output | AW | Read address for the Q operand byte |
| rd_data_b | input | 8 | Combinational read data at `rd_addr_b` |
| wr_en | output | 1 | Write strobe for the result byte |
| wr_addr | output | AW | Result byte address |
| wr_data | output | 8 | Result byte |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle pulse after the last write |
| carry | output | 1 | Carry or borrow out of the most significant byte |
| zero | output | 1 | All result bytes were zero |

## Verification
The assertion on result digits assumes that every operand byte the unit reads holds two valid BCD digits. The stimulus therefore fills the RAM regions only with values built from digits 0..9, and it draws accumulator values the same way.

The checks on address stepping and data assume that the P region and the Q region do not overlap. Random operations keep P in a low window and Q in a high window that no walk can reach.

// File: rtl/bcd_arith_pkg.sv
// Shared definitions for the packed BCD arithmetic unit.
// Assumes: op bit0 selects subtraction, op bit1 selects the memory operand.
package bcd_arith_pkg;

    typedef enum logic [1:0] {
        OP_ADD_ACC = 2'b00,
        OP_SUB_ACC = 2'b01,
        OP_ADD_MEM = 2'b10,
        OP_SUB_MEM = 2'b11
    } bcd_op_e;

    localparam int DIGIT_W = 4;

endpackage

// File: rtl/bcd_digit_cell.sv
// One decimal digit stage: adds or subtracts two BCD digits with carry/borrow.
// Assumes: inputs are valid BCD digits (0..9); otherwise the result is undefined.
module bcd_digit_cell
    import bcd_arith_pkg::*;
(
    input  logic [DIGIT_W-1:0] a,
    input  logic [DIGIT_W-1:0] b,
    input  logic               sub,
    input  logic               cin,
    output logic [DIGIT_W-1:0] y,
    output logic               cout
);
    logic [DIGIT_W:0] raw;

    // Binary sum or difference followed by decimal correction.
    always_comb begin
        if (sub) begin
            raw = {1'b0, a} - {1'b0, b} - {{DIGIT_W{1'b0}}, cin};
            cout = raw[DIGIT_W];
            y = raw[DIGIT_W] ? DIGIT_W'(raw + 5'd10) : raw[DIGIT_W-1:0];
        end else begin
            raw = {1'b0, a} + {1'b0, b} + {{DIGIT_W{1'b0}}, cin};
            cout = (raw > 5'd9);
            y = (raw > 5'd9) ? DIGIT_W'(raw + 5'd6) : raw[DIGIT_W-1:0];
        end
    end
endmodule

// File: rtl/bcd_byte_alu.sv
// Chains DIGITS digit cells into one packed BCD byte operation.
// Assumes: digit 0 sits in the low nibble; the carry enters at digit 0.
module bcd_byte_alu
    import bcd_arith_pkg::*;
#(
    parameter int DIGITS = 2,
    localparam int BW = DIGITS * DIGIT_W
) (
    input  logic [BW-1:0] a,
    input  logic [BW-1:0] b,
    input  logic          sub,
    input  logic          cin,
    output logic [BW-1:0] y,
    output logic          cout
);
    logic [DIGITS:0] chain;

    assign chain[0] = cin;
    assign cout     = chain[DIGITS];

    for (genvar d = 0; d < DIGITS; d++) begin : g_digit
        bcd_digit_cell u_cell (
            .a    (a[d*DIGIT_W +: DIGIT_W]),
            .b    (b[d*DIGIT_W +: DIGIT_W]),
            .sub  (sub),
            .cin  (chain[d]),
            .y    (y[d*DIGIT_W +: DIGIT_W]),
            .cout (chain[d+1])
        );
    end
endmodule

// File: rtl/bcd_walk_ctrl.sv
// Walk sequencer: accepts a command, steps both pointers downward once per
// cycle for span+1 cycles, then pulses done.
// Assumes: start is ignored while busy; pointers wrap modulo 2**AW.
module bcd_walk_ctrl #(
    parameter int AW = 7,
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [AW-1:0] p_ptr,
    input  logic [AW-1:0] q_ptr,
    input  logic [CW-1:0] span,
    output logic          busy,
    output logic          done,
    output logic          first,
    output logic          last,
    output logic          accept,
    output logic [AW-1:0] cur_p,
    output logic [AW-1:0] cur_q
);
    logic [CW-1:0] remain;

    assign accept = start && !busy;
    assign last   = busy && (remain == '0);

    // Load on accept, step while busy, finish after the final byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy   <= 1'b0;
            done   <= 1'b0;
            first  <= 1'b0;
            remain <= '0;
            cur_p  <= '0;
            cur_q  <= '0;
        end else begin
            done <= 1'b0;
            if (accept) begin
                busy   <= 1'b1;
                first  <= 1'b1;
                remain <= span;
                cur_p  <= p_ptr;
                cur_q  <= q_ptr;
            end else if (last) begin
                busy <= 1'b0;
                done <= 1'b1;
            end else if (busy) begin
                first  <= 1'b0;
                remain <= remain - 1'b1;
                cur_p  <= cur_p - 1'b1;
                cur_q  <= cur_q - 1'b1;
            end
        end
    end
endmodule

// File: rtl/bcd_arith_unit.sv
// Multi-byte packed BCD add/subtract over a scratch RAM, one byte per cycle,
// least significant byte first, walking toward lower addresses.
// Assumes: combinational RAM reads, operands are valid BCD, and the P and Q
// regions do not overlap.
module bcd_arith_unit
    import bcd_arith_pkg::*;
#(
    parameter int AW = 7,
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [1:0]    op,
    input  logic [7:0]    acc,
    input  logic [AW-1:0] p_ptr,
    input  logic [AW-1:0] q_ptr,
    input  logic [CW-1:0] span,
    output logic [AW-1:0] rd_addr_a,
    input  logic [7:0]    rd_data_a,
    output logic [AW-1:0] rd_addr_b,
    input  logic [7:0]    rd_data_b,
    output logic          wr_en,
    output logic [AW-1:0] wr_addr,
    output logic [7:0]    wr_data,
    output logic          busy,
    output logic          done,
    output logic          carry,
    output logic          zero
);
    bcd_op_e    op_q;
    logic [7:0] acc_q;
    logic       chain_q;
    logic       zero_run;
    logic       first, last, accept;
    logic [7:0] operand_b;
    logic [7:0] result;
    logic       step_cout;
    logic       is_sub, use_mem;

    bcd_walk_ctrl #(.AW(AW), .CW(CW)) u_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (start),
        .p_ptr  (p_ptr),
        .q_ptr  (q_ptr),
        .span   (span),
        .busy   (busy),
        .done   (done),
        .first  (first),
        .last   (last),
        .accept (accept),
        .cur_p  (rd_addr_a),
        .cur_q  (rd_addr_b)
    );

    assign is_sub  = (op_q == OP_SUB_ACC) || (op_q == OP_SUB_MEM);
    assign use_mem = (op_q == OP_ADD_MEM) || (op_q == OP_SUB_MEM);

    // Second operand: memory byte, or accumulator on the first byte only.
    always_comb begin
        if (use_mem)    operand_b = rd_data_b;
        else if (first) operand_b = acc_q;
        else            operand_b = 8'h00;
    end

    bcd_byte_alu #(.DIGITS(2)) u_alu (
        .a    (rd_data_a),
        .b    (operand_b),
        .sub  (is_sub),
        .cin  (first ? 1'b0 : chain_q),
        .y    (result),
        .cout (step_cout)
    );

    assign wr_en   = busy;
    assign wr_addr = rd_addr_a;
    assign wr_data = result;

    // Capture the command, carry the chain, and publish flags at the end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q     <= OP_ADD_ACC;
            acc_q    <= '0;
            chain_q  <= 1'b0;
            zero_run <= 1'b1;
            carry    <= 1'b0;
            zero     <= 1'b0;
        end else if (accept) begin
            op_q     <= bcd_op_e'(op);
            acc_q    <= acc;
            chain_q  <= 1'b0;
            zero_run <= 1'b1;
        end else if (busy) begin
            chain_q  <= step_cout;
            zero_run <= zero_run && (result == 8'h00);
            if (last) begin
                carry <= step_cout;
                zero  <= zero_run && (result == 8'h00);
            end
        end
    end
endmodule

// File: rtl/bcd_arith_checker.sv
// Temporal checks on the BCD arithmetic unit's ports, bound to every instance.
// Assumes: operand bytes read from RAM hold valid BCD digits.
module bcd_arith_checker #(
    parameter int AW = 7
) (
    input logic          clk,
    input logic          rst_n,
    input logic          busy,
    input logic          done,
    input logic          wr_en,
    input logic [AW-1:0] wr_addr,
    input logic [AW-1:0] rd_addr_a,
    input logic [7:0]    wr_data,
    input logic          zero,
    input logic          carry
);
    assert_reset_quiet_R1: assert property (@(posedge clk)
        !rst_n |=> (!busy && !done && !wr_en && !carry && !zero));

    assert_digit_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (wr_data[3:0] <= 4'd9 && wr_data[7:4] <= 4'd9));

    assert_addr_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && $past(wr_en)) |-> (wr_addr == AW'($past(wr_addr) - 1'b1)));

    assert_write_tracks_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (wr_addr == rd_addr_a));

    assert_zero_last_byte_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) && zero |-> ($past(wr_data) == 8'h00));

    assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_done_after_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(wr_en) && !wr_en && !busy));
endmodule

bind bcd_arith_unit bcd_arith_checker #(.AW(AW)) u_bcd_arith_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy      (busy),
    .done      (done),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .rd_addr_a (rd_addr_a),
    .wr_data   (wr_data),
    .zero      (zero),
    .carry     (carry)
);

// File: tb/bcd_arith_unit_bench.sv
// Scoreboard bench: the driver predicts writes and flags into queues, and the
// monitor compares them against the RAM write port and the done pulse.
module bcd_arith_unit_bench;
    localparam int AW = 7;
    localparam int CW = 8;
    localparam int DEPTH = 1 << AW;

    typedef struct { logic [AW-1:0] addr; logic [7:0] data; string tag; } wr_item_t;
    typedef struct { logic c; logic z; string tag; } flag_item_t;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          start;
    logic [1:0]    op;
    logic [7:0]    acc;
    logic [AW-1:0] p_ptr, q_ptr;
    logic [CW-1:0] span;
    logic [AW-1:0] rd_addr_a, rd_addr_b, wr_addr;
    logic [7:0]    rd_data_a, rd_data_b, wr_data;
    logic          wr_en, busy, done, carry, zero;

    logic [7:0] mem [DEPTH];
    wr_item_t   exp_wr[$];
    flag_item_t exp_fl[$];
    int checks = 0;
    int failures = 0;

    always #2 clk = ~clk;

    bcd_arith_unit #(.AW(AW), .CW(CW)) u_bcd_arith_unit (
        .clk(clk), .rst_n(rst_n), .start(start), .op(op), .acc(acc),
        .p_ptr(p_ptr), .q_ptr(q_ptr), .span(span),
        .rd_addr_a(rd_addr_a), .rd_data_a(rd_data_a),
        .rd_addr_b(rd_addr_b), .rd_data_b(rd_data_b),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .busy(busy), .done(done), .carry(carry), .zero(zero)
    );

    assign rd_data_a = mem[rd_addr_a];
    assign rd_data_b = mem[rd_addr_b];

    // RAM model write port.
    always @(posedge clk) if (wr_en) mem[wr_addr] <= wr_data;

    function automatic int dec(input logic [7:0] v);
        return int'(v[7:4]) * 10 + int'(v[3:0]);
    endfunction

    function automatic logic [7:0] enc(input int v);
        return {4'(v / 10), 4'(v % 10)};
    endfunction

    function automatic int wrap(input int a);
        return ((a % DEPTH) + DEPTH) % DEPTH;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    // Driver: predict every write and the final flags, then issue the command.
    task automatic run_op(input logic [1:0] o, input logic [7:0] a, input int p,
                          input int q, input int n, input string tag, input bit poke);
        int c = 0;
        bit allz = 1'b1;
        for (int k = 0; k <= n; k++) begin
            int pv, bv, r;
            pv = dec(mem[wrap(p - k)]);
            if (o[1]) bv = dec(mem[wrap(q - k)]);
            else      bv = (k == 0) ? dec(a) : 0;
            if (!o[0]) begin
                r = pv + bv + c;
                c = (r >= 100) ? 1 : 0;
                if (c == 1) r -= 100;
            end else begin
                r = pv - bv - c;
                c = (r < 0) ? 1 : 0;
                if (c == 1) r += 100;
            end
            if (r != 0) allz = 1'b0;
            exp_wr.push_back('{AW'(wrap(p - k)), enc(r), tag});
        end
        exp_fl.push_back('{c[0], allz, tag});
        @(negedge clk);
        op = o; acc = a; p_ptr = AW'(p); q_ptr = AW'(q); span = CW'(n);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (poke) begin
            @(negedge clk);
            op = ~o; acc = 8'h55; p_ptr = AW'(p - 40); span = 8'd9;
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            check(busy == 1'b1, "R10 busy kept after ignored start", int'(busy), 1);
        end
        while (!done) @(negedge clk);
        @(negedge clk);
        check(done == 1'b0, "R9 done lasts one cycle", int'(done), 0);
    endtask

    // Monitor: compare each write and each done against the scoreboard.
    always @(negedge clk) begin
        if (rst_n === 1'b1) begin
            if (wr_en) begin
                if (exp_wr.size() == 0) begin
                    check(1'b0, "R10 unexpected write", int'(wr_addr), -1);
                end else begin
                    wr_item_t it;
                    it = exp_wr.pop_front();
                    check(wr_addr == it.addr, {it.tag, " R3 write address"}, int'(wr_addr), int'(it.addr));
                    check(wr_data == it.data, {it.tag, " R2 result byte"}, int'(wr_data), int'(it.data));
                end
            end
            if (done) begin
                check(exp_wr.size() == 0, "R9 done before all writes", exp_wr.size(), 0);
                if (exp_fl.size() == 0) begin
                    check(1'b0, "R10 unexpected done", 1, 0);
                end else begin
                    flag_item_t f;
                    f = exp_fl.pop_front();
                    check(carry == f.c, {f.tag, " R7 carry"}, int'(carry), int'(f.c));
                    check(zero == f.z, {f.tag, " R8 zero"}, int'(zero), int'(f.z));
                end
            end
        end
    end

    function automatic logic [7:0] rand_bcd();
        return {4'($urandom_range(9)), 4'($urandom_range(9))};
    endfunction

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    // Stimulus sequence.
    initial begin
        rst_n = 1'b0; start = 1'b0; op = 2'b00; acc = 8'h00;
        p_ptr = '0; q_ptr = '0; span = '0;
        for (int i = 0; i < DEPTH; i++) mem[i] = 8'h00;
        repeat (3) @(negedge clk);
        check(!busy && !done && !wr_en && !carry && !zero, "R1 outputs in reset",
              {busy, done, wr_en, carry, zero}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy && !done && !wr_en && !carry && !zero, "R1 outputs after reset",
              {busy, done, wr_en, carry, zero}, 0);

        // R4: accumulator add ripples a carry out of the low byte.
        mem[20] = 8'h12; mem[21] = 8'h99;
        run_op(2'b00, 8'h01, 21, 0, 1, "R4 acc add", 1'b0);
        check(mem[21] == 8'h00, "R4 low byte", int'(mem[21]), 'h00);
        check(mem[20] == 8'h13, "R4 carried byte", int'(mem[20]), 'h13);

        // R7/R8: all-nines plus one overflows to zero.
        mem[10] = 8'h99; mem[11] = 8'h99; mem[12] = 8'h99;
        run_op(2'b00, 8'h01, 12, 0, 2, "R7 R8 acc overflow", 1'b0);
        check(carry == 1'b1 && zero == 1'b1, "R7 R8 overflow flags", {carry, zero}, 3);

        // R6: accumulator subtract borrows through every byte.
        mem[14] = 8'h00; mem[15] = 8'h00;
        run_op(2'b01, 8'h01, 15, 0, 1, "R6 acc sub", 1'b0);
        check(mem[14] == 8'h99 && mem[15] == 8'h99, "R6 borrow result",
              int'({mem[14], mem[15]}), 'h9999);

        // R5: memory add with a carry chain.
        mem[30] = 8'h45; mem[31] = 8'h67; mem[32] = 8'h89;
        mem[60] = 8'h54; mem[61] = 8'h32; mem[62] = 8'h11;
        run_op(2'b10, 8'h00, 32, 62, 2, "R5 mem add", 1'b0);

        // R6/R8: equal numbers subtract to zero with no borrow.
        mem[40] = 8'h31; mem[41] = 8'h41;
        mem[70] = 8'h31; mem[71] = 8'h41;
        run_op(2'b11, 8'h00, 41, 71, 1, "R6 R8 equal sub", 1'b0);
        check(zero == 1'b1 && carry == 1'b0, "R8 equal sub flags", {carry, zero}, 1);

        // R3: single-byte operation.
        mem[25] = 8'h58;
        run_op(2'b00, 8'h47, 25, 0, 0, "R3 single byte", 1'b0);

        // R11: the walk wraps below address zero.
        mem[1] = 8'h09; mem[0] = 8'h99; mem[127] = 8'h50; mem[126] = 8'h07;
        mem[60] = 8'h91; mem[59] = 8'h01; mem[58] = 8'h49; mem[57] = 8'h02;
        run_op(2'b10, 8'h00, 1, 60, 3, "R11 wrap", 1'b0);
        check(mem[1] == 8'h00 && mem[0] == 8'h01 && mem[127] == 8'h00 && mem[126] == 8'h10,
              "R11 wrapped bytes", int'({mem[126], mem[127], mem[0], mem[1]}), 'h10000100);

        // R10: a start pulse during the walk is ignored.
        for (int i = 0; i < 6; i++) begin
            mem[20 - i] = rand_bcd();
            mem[80 - i] = rand_bcd();
        end
        run_op(2'b11, 8'h00, 20, 80, 5, "R10 ignored start", 1'b1);

        // Random mix of operations on disjoint regions.
        for (int t = 0; t < 24; t++) begin
            int p, q, n;
            p = 10 + $urandom_range(19);
            q = 70 + $urandom_range(19);
            n = $urandom_range(5);
            for (int i = 0; i <= n; i++) begin
                mem[wrap(p - i)] = rand_bcd();
                mem[wrap(q - i)] = rand_bcd();
            end
            run_op(2'($urandom_range(3)), rand_bcd(), p, q, n, "R2 R5 R6 random", 1'b0);
        end

        check(exp_wr.size() == 0 && exp_fl.size() == 0, "R9 scoreboard drained",
              exp_wr.size() + exp_fl.size(), 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule